// File: doc/BRIEF.md
# NAND Block Health Tracker

This block keeps a per-block health record for a NAND target model or flash controller: one "bad" flag and one signed remaining-erase counter for every erase block. A command sequencer opens an initialisation by pulsing a start strobe with a default endurance value. It then streams the indices of factory-bad blocks, which the block records until an end marker, an out-of-range index or the list capacity closes the list. After that, every completed erase reports its block index, and the sequencer asks through a combinational lookup whether a given block may still be used.

The counter uses a signed encoding. Zero means the block is worn out. A positive value counts the erases that remain. A negative value, which the all-ones "unlimited" code loaded for a zero default belongs to, never wears out. The number of blocks is the product of the blocks per logical unit and the number of logical units.

Top module: `nand_blk_health`

## Requirements
- R1: After reset every counter is zero and no block is marked bad, so `query_valid` and `query_wear` read 0 for any block, and `init_busy` and `init_err` are low.
- R2: A cycle with `init_start` high loads every counter with `init_wear`, clears every bad flag and `init_err`, and raises `init_busy` from the next cycle.
- R3: When `init_wear` is zero at `init_start`, every counter is loaded with all ones (-1, unlimited) instead.
- R4: While `init_busy` is high, a `bad_valid` entry whose `bad_index` is below the block count marks that block bad. The last block, index count-1, is accepted.
- R5: A `bad_valid` entry equal to 32'hFFFF_FFFF closes the list (`init_busy` low next cycle) and raises no error.
- R6: A `bad_valid` entry that is not the end marker and not below the block count sets `init_err` and closes the list. `init_err` holds until the next `init_start`.
- R7: The list closes after MAX_BAD accepted indices. `bad_valid` entries while `init_busy` is low have no effect.
- R8: `query_valid` is high only when the queried block is not marked bad and its counter is not zero. It is combinational from stored state.
- R9: An `erase_en` cycle decrements the addressed counter by one only when it is positive. Zero and negative counters stay unchanged.
- R10: When an erase and a query hit the same block in one cycle, the query shows the pre-erase state. The new count is visible from the next cycle.
- R11: `init_start` takes priority over an `erase_en` or `bad_valid` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| init_start | input | 1 | Begin initialisation |
| init_wear | input | WEAR_W | Default endurance value, signed |
| bad_valid | input | 1 | Bad-list entry strobe |
| bad_index | input | IDX_W | Bad-list entry or end marker |
| init_busy | output | 1 | Bad list is open |
| init_err | output | 1 | Out-of-range index seen in this initialisation |
| erase_en | input | 1 | Erase completed strobe |
| erase_blk | input | BLK_W | Erased block index |
| query_blk | input | BLK_W | Block index to look up |
| query_valid | output | 1 | Queried block is usable |
| query_wear | output | WEAR_W | Queried block's counter, signed |

## Verification
The assertions check the list protocol on every cycle: an initialisation opens the list, the end marker closes it cleanly, an out-of-range index closes it with a sticky error, and a zero count is never reported valid. They also check the counters on every cycle: a positive count drops by exactly one under an erase, non-positive counts stay put, and a zero default loads the unlimited code. Only the bench scenarios can show that a given bad index lands on the right block and leaves its neighbours alone. The same holds for the capacity limit, for entries arriving after the list has closed, and for the same-cycle orderings of erase, query and initialisation.

// File: rtl/nand_blk_health.sv
module nand_blk_health #(
  parameter int BLKS_PER_LUN = 16,
  parameter int NUM_LUNS     = 2,
  parameter int WEAR_W       = 16,
  parameter int MAX_BAD      = 8,
  parameter int IDX_W        = 32,
  localparam int NUM_BLKS    = BLKS_PER_LUN * NUM_LUNS,
  localparam int BLK_W       = (NUM_BLKS > 1) ? $clog2(NUM_BLKS) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     init_start,
  input  logic [WEAR_W-1:0]        init_wear,
  input  logic                     bad_valid,
  input  logic [IDX_W-1:0]         bad_index,
  output logic                     init_busy,
  output logic                     init_err,
  input  logic                     erase_en,
  input  logic [BLK_W-1:0]         erase_blk,
  input  logic [BLK_W-1:0]         query_blk,
  output logic                     query_valid,
  output logic signed [WEAR_W-1:0] query_wear
);
  localparam logic [IDX_W-1:0] END_MARK = '1;
  localparam int CNT_W = $clog2(MAX_BAD + 1);

  logic signed [WEAR_W-1:0] wear_q [NUM_BLKS];
  logic [NUM_BLKS-1:0]      bad_q;
  logic                     busy_q, err_q;
  logic [CNT_W-1:0]         cnt_q;
  logic signed [WEAR_W-1:0] load_val;
  logic                     list_take, is_end, in_range, mark_hit, last_slot;
  logic [BLK_W-1:0]         mark_blk;

  assign load_val  = (init_wear == '0) ? '1 : init_wear;
  assign list_take = busy_q & bad_valid & ~init_start;
  assign is_end    = (bad_index == END_MARK);
  assign in_range  = (bad_index < IDX_W'(NUM_BLKS));
  assign mark_hit  = list_take & ~is_end & in_range;
  assign last_slot = (cnt_q == CNT_W'(MAX_BAD - 1));
  assign mark_blk  = bad_index[BLK_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      err_q  <= 1'b0;
      cnt_q  <= '0;
    end else if (init_start) begin
      busy_q <= 1'b1;
      err_q  <= 1'b0;
      cnt_q  <= '0;
    end else if (list_take) begin
      if (is_end) begin
        busy_q <= 1'b0;
      end else if (!in_range) begin
        err_q  <= 1'b1;
        busy_q <= 1'b0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
        if (last_slot) busy_q <= 1'b0;
      end
    end
  end

  for (genvar g = 0; g < NUM_BLKS; g++) begin : g_blk
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        wear_q[g] <= '0;
        bad_q[g]  <= 1'b0;
      end else if (init_start) begin
        wear_q[g] <= load_val;
        bad_q[g]  <= 1'b0;
      end else begin
        if (mark_hit && mark_blk == BLK_W'(g)) bad_q[g] <= 1'b1;
        if (erase_en && erase_blk == BLK_W'(g) && wear_q[g] > 0)
          wear_q[g] <= wear_q[g] - 1'b1;
      end
    end
  end

  assign query_wear  = wear_q[query_blk];
  assign query_valid = ~bad_q[query_blk] & (query_wear != '0);
  assign init_busy   = busy_q;
  assign init_err    = err_q;
endmodule

// File: rtl/nand_blk_health_chk.sv
module nand_blk_health_chk #(
  parameter int NUM_BLKS = 32,
  parameter int WEAR_W   = 16,
  parameter int IDX_W    = 32,
  parameter int BLK_W    = 5
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     init_start,
  input logic [WEAR_W-1:0]        init_wear,
  input logic                     bad_valid,
  input logic [IDX_W-1:0]         bad_index,
  input logic                     init_busy,
  input logic                     init_err,
  input logic                     erase_en,
  input logic [BLK_W-1:0]         erase_blk,
  input logic [BLK_W-1:0]         query_blk,
  input logic                     query_valid,
  input logic signed [WEAR_W-1:0] query_wear
);
  logic entry, marker, too_big;
  assign entry   = init_busy && bad_valid && !init_start;
  assign marker  = (bad_index == '1);
  assign too_big = (bad_index >= IDX_W'(NUM_BLKS));

  assert_open_on_init_R2: assert property (@(posedge clk) disable iff (!rst_n)
    init_start |=> init_busy && !init_err);

  assert_unlimited_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    init_start && init_wear == '0 |=> query_wear == -1);

  assert_end_mark_R5: assert property (@(posedge clk) disable iff (!rst_n)
    entry && marker |=> !init_busy && !init_err);

  assert_range_err_R6: assert property (@(posedge clk) disable iff (!rst_n)
    entry && !marker && too_big |=> init_err && !init_busy);

  assert_err_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    init_err && !init_start |=> init_err);

  assert_zero_invalid_R8: assert property (@(posedge clk) disable iff (!rst_n)
    query_wear == '0 |-> !query_valid);

  assert_decrement_R9: assert property (@(posedge clk) disable iff (!rst_n)
    erase_en && !init_start && erase_blk == query_blk && query_wear > 0
    |=> !$stable(query_blk) || query_wear == $past(query_wear) - 1);

  assert_nonpos_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    query_wear <= 0 && !init_start |=> !$stable(query_blk) || $stable(query_wear));
endmodule

bind nand_blk_health nand_blk_health_chk #(
  .NUM_BLKS(NUM_BLKS), .WEAR_W(WEAR_W), .IDX_W(IDX_W), .BLK_W(BLK_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .init_start(init_start), .init_wear(init_wear),
  .bad_valid(bad_valid), .bad_index(bad_index), .init_busy(init_busy),
  .init_err(init_err), .erase_en(erase_en), .erase_blk(erase_blk),
  .query_blk(query_blk), .query_valid(query_valid), .query_wear(query_wear)
);

// File: tb/test_nand_blk_health.sv
`timescale 1ns/100ps
module test_nand_blk_health;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic init_start = 1'b0;
  logic [15:0] init_wear = '0;
  logic bad_valid = 1'b0;
  logic [31:0] bad_index = '0;
  logic erase_en = 1'b0;
  logic [4:0] erase_blk = '0;
  logic [4:0] query_blk = '0;
  logic init_busy, init_err, query_valid;
  logic signed [15:0] query_wear;

  int nchk = 0;
  int nfail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  nand_blk_health i_nand_blk_health (
    .clk(clk), .rst_n(rst_n), .init_start(init_start), .init_wear(init_wear),
    .bad_valid(bad_valid), .bad_index(bad_index), .init_busy(init_busy),
    .init_err(init_err), .erase_en(erase_en), .erase_blk(erase_blk),
    .query_blk(query_blk), .query_valid(query_valid), .query_wear(query_wear)
  );

  // op: 0 init(data=wear) 1 bad entry(data=index) 2 erase(blk) 3 query(blk, expect)
  localparam int NV = 16;
  localparam logic [55:0] VEC [NV] = '{
    {2'd0, 5'd0,  32'd3,          1'b0, 16'd0},
    {2'd1, 5'd0,  32'd5,          1'b0, 16'd0},
    {2'd1, 5'd0,  32'd9,          1'b0, 16'd0},
    {2'd1, 5'd0,  32'hFFFF_FFFF,  1'b0, 16'd0},
    {2'd3, 5'd5,  32'd0,          1'b0, 16'd3},
    {2'd3, 5'd9,  32'd0,          1'b0, 16'd3},
    {2'd3, 5'd0,  32'd0,          1'b1, 16'd3},
    {2'd2, 5'd0,  32'd0,          1'b0, 16'd0},
    {2'd3, 5'd0,  32'd0,          1'b1, 16'd2},
    {2'd2, 5'd0,  32'd0,          1'b0, 16'd0},
    {2'd2, 5'd0,  32'd0,          1'b0, 16'd0},
    {2'd3, 5'd0,  32'd0,          1'b0, 16'd0},
    {2'd2, 5'd0,  32'd0,          1'b0, 16'd0},
    {2'd3, 5'd0,  32'd0,          1'b0, 16'd0},
    {2'd3, 5'd1,  32'd0,          1'b1, 16'd3},
    {2'd3, 5'd6,  32'd0,          1'b1, 16'd3}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input logic s, input logic [15:0] w, input logic bv,
                      input logic [31:0] bi, input logic ee, input logic [4:0] eb);
    @(negedge clk);
    init_start = s; init_wear = w; bad_valid = bv; bad_index = bi;
    erase_en = ee; erase_blk = eb;
    @(posedge clk);
    #1;
    init_start = 1'b0; bad_valid = 1'b0; erase_en = 1'b0;
  endtask

  task automatic look(input string tag, input logic [4:0] b, input logic ev,
                      input logic [15:0] ew);
    query_blk = b;
    #0.5;
    chk({tag, " valid"}, 32'(query_valid), 32'(ev));
    chk({tag, " wear"}, 32'($unsigned(query_wear)), 32'(ew));
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;
    // R1 reset state
    look("R1 reset blk0", 5'd0, 1'b0, 16'd0);
    chk("R1 busy", 32'(init_busy), 32'd0);
    chk("R1 err", 32'(init_err), 32'd0);

    // table walk: R2 R4 R5 R8 R9
    for (int i = 0; i < NV; i++) begin
      logic [55:0] v;
      v = VEC[i];
      case (v[55:54])
        2'd0: step(1'b1, v[48:17], 1'b0, '0, 1'b0, '0);
        2'd1: step(1'b0, '0, 1'b1, v[48:17], 1'b0, '0);
        2'd2: step(1'b0, '0, 1'b0, '0, 1'b1, v[53:49]);
        default: look($sformatf("R4 R8 R9 entry %0d", i), v[53:49], v[16], v[15:0]);
      endcase
    end
    chk("R5 list closed", 32'(init_busy), 32'd0);
    chk("R5 no err", 32'(init_err), 32'd0);

    // R2 R3 unlimited code
    step(1'b1, 16'd0, 1'b0, '0, 1'b0, '0);
    chk("R2 busy after init", 32'(init_busy), 32'd1);
    look("R3 unlimited load", 5'd7, 1'b1, 16'hFFFF);
    look("R2 bad cleared", 5'd5, 1'b1, 16'hFFFF);
    step(1'b0, '0, 1'b0, '0, 1'b1, 5'd7);
    look("R9 unlimited kept", 5'd7, 1'b1, 16'hFFFF);

    // R6 range error, sticky, cleared by init
    step(1'b1, 16'd4, 1'b0, '0, 1'b0, '0);
    step(1'b0, '0, 1'b1, 32'd32, 1'b0, '0);
    chk("R6 err set", 32'(init_err), 32'd1);
    chk("R6 list closed", 32'(init_busy), 32'd0);
    step(1'b0, '0, 1'b1, 32'd3, 1'b0, '0);
    look("R7 entry after close ignored", 5'd3, 1'b1, 16'd4);
    step(1'b0, '0, 1'b0, '0, 1'b1, 5'd2);
    chk("R6 err held", 32'(init_err), 32'd1);
    step(1'b1, 16'd4, 1'b0, '0, 1'b0, '0);
    chk("R6 err cleared", 32'(init_err), 32'd0);

    // R7 capacity of 8 entries
    for (int k = 0; k < 8; k++) begin
      chk("R7 open before cap", 32'(init_busy), 32'd1);
      step(1'b0, '0, 1'b1, 32'(k), 1'b0, '0);
    end
    chk("R7 closed at cap", 32'(init_busy), 32'd0);
    step(1'b0, '0, 1'b1, 32'd10, 1'b0, '0);
    look("R7 over cap ignored", 5'd10, 1'b1, 16'd4);
    look("R4 eighth entry marked", 5'd7, 1'b0, 16'd4);

    // R4 last block index accepted
    step(1'b1, 16'd2, 1'b0, '0, 1'b0, '0);
    step(1'b0, '0, 1'b1, 32'd31, 1'b0, '0);
    chk("R4 last idx no err", 32'(init_err), 32'd0);
    look("R4 last block bad", 5'd31, 1'b0, 16'd2);
    look("R4 neighbour ok", 5'd30, 1'b1, 16'd2);
    step(1'b0, '0, 1'b1, 32'hFFFF_FFFF, 1'b0, '0);

    // R10 same-cycle erase and query
    @(negedge clk);
    erase_en = 1'b1; erase_blk = 5'd12; query_blk = 5'd12;
    #0.5;
    chk("R10 pre-erase wear", 32'($unsigned(query_wear)), 32'd2);
    @(posedge clk);
    #1;
    erase_en = 1'b0;
    chk("R10 post-erase wear", 32'($unsigned(query_wear)), 32'd1);

    // R11 init beats erase and bad entry
    step(1'b0, '0, 1'b0, '0, 1'b0, '0);
    @(negedge clk);
    init_start = 1'b1; init_wear = 16'd5; erase_en = 1'b1; erase_blk = 5'd12;
    bad_valid = 1'b1; bad_index = 32'd12;
    @(posedge clk);
    #1;
    init_start = 1'b0; erase_en = 1'b0; bad_valid = 1'b0;
    look("R11 init priority", 5'd12, 1'b1, 16'd5);

    done = 1'b1;
    finish_run();
  end
endmodule